// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block collects up to fifteen level-sensitive interrupt request lines and presents one interrupt request to a processor. It is built from two identical eight-input priority units. The upper unit (lines 8 to 15) resolves its own winner and feeds the result into input 2 of the lower unit (lines 0 to 7). Each unit keeps its own mask, request and in-service registers. All masks are set at reset, so software has to open a line before that line can interrupt.

An acknowledge handshake is run by a small state machine with three states:
- `ST_IDLE`: no request is being offered.
- `ST_PEND`: `cpu_irq` is high and the block is waiting for `ack`.
- `ST_VEC`: the vector is presented for one cycle.

The transitions are:
- `ST_IDLE`→`ST_PEND` when a deliverable request exists.
- `ST_PEND`→`ST_IDLE` when that request vanishes before the acknowledge.
- `ST_PEND`→`ST_VEC` on `ack`.
- `ST_VEC`→`ST_IDLE` always.

On the acknowledge, the winning request moves into service and the vector becomes `VEC_BASE` plus the line number. Software finishes each interrupt with non-specific end-of-interrupt commands sent through a one-cycle command port. An interrupt from the upper unit needs one command to each unit.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `cpu_irq` and `vec_valid` are low, the request and in-service registers are empty, and every mask bit is set. A request raised before any mask write therefore never raises `cpu_irq`.
- R2: The command port writes a mask when `cmd_valid`=1 and `cmd_op`=0. `cmd_sel`=0 addresses the lower unit and `cmd_sel`=1 the upper unit. A mask bit of 1 blocks its line and a 0 lets it through. A line can raise `cpu_irq` only while its mask bit is 0.
- R3: Inside a unit, input 0 has the highest priority and input 7 the lowest. When several lines are pending, the acknowledge returns `VEC_BASE` + the lowest-numbered line (`VEC_BASE` = 0x20 by default).
- R4: A request on an upper line (8 to 15) takes the priority position of lower input 2. It beats lines 3 to 7, loses to lines 0 and 1, and is blocked as a group while lower mask bit 2 is set.
- R5: `cpu_irq` goes high two clock edges after an unmasked winning line rises. An `ack` while `cpu_irq` is high makes `vec_valid` high for exactly the next cycle, with `vec_out` = `VEC_BASE` + line (0 to 15). `cpu_irq` is low in that cycle.
- R6: A line in service blocks requests of equal or lower priority in its unit. A request of strictly higher priority still interrupts, which gives nesting.
- R7: The end-of-interrupt command is `cmd_valid`=1 with `cmd_op`=1, and it goes to the unit chosen by `cmd_sel`. It clears the highest-priority in-service bit of that unit. After an upper-line interrupt, clearing only the upper unit leaves lower input 2 in service, which still blocks lines 2 to 7.
- R8: Requests are level-sensitive. A line that drops before the acknowledge leaves the request register, `cpu_irq` falls, and a later `ack` returns no vector.
- R9: Bit 2 of `req_in` has no effect, because that input position is taken by the cascade.
- R10: An `ack` while `cpu_irq` is low is ignored and produces no `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 16 | Level request lines; bit n is line n, bit 2 unused |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 1 | 0 = write mask, 1 = non-specific end of interrupt |
| cmd_sel | input | 1 | 0 = lower unit, 1 = upper unit |
| cmd_data | input | 8 | New mask value for a mask write |
| ack | input | 1 | Processor acknowledge |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid strobe, one cycle |
| vec_out | output | 8 | Vector number, base plus line |

## Verification
A corrupted in-service register shows up as a wrong nesting decision. Either `cpu_irq` stays low two cycles after a higher-priority line rises, or it reappears right after an end-of-interrupt that should not have released a lower line. A wrong mask or cascade slot shows within two edges as a `cpu_irq` that should not be there. A wrong priority pick shows at the very next acknowledge as a wrong `vec_out`. A handshake state that is stuck or skipped shows as a `vec_valid` that lasts more or less than one cycle, or as one that appears for a dropped line.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_VEC  = 2'd2
    } ack_state_e;

    typedef enum logic {
        OP_MASK = 1'b0,
        OP_EOI  = 1'b1
    } cmd_op_e;
endpackage

// File: rtl/intc_pri_unit.sv
`timescale 1ns/1ps
module intc_pri_unit #(
    parameter int W        = 8,
    parameter bit HAS_CASC = 1'b0,
    parameter int CASC_POS = 2,
    localparam int IW      = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  req_lvl,
    input  logic          casc_in,
    input  logic          mask_we,
    input  logic [W-1:0]  mask_din,
    input  logic          eoi,
    input  logic          take,
    output logic          int_out,
    output logic [IW-1:0] win_idx
);
    localparam logic [W-1:0] CASC_BIT = HAS_CASC ? (W'(1) << CASC_POS) : '0;

    logic [W-1:0]  irr_q;
    logic [W-1:0]  imr_q;
    logic [W-1:0]  isr_q;
    logic [W-1:0]  isr_d;
    logic [W-1:0]  eff;
    logic [W-1:0]  pend;
    logic          win_any;
    logic          isr_any;
    logic [IW-1:0] isr_top;

    // level capture; the cascade slot is replaced by the live input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= req_lvl;
    end

    always_comb begin
        eff  = (irr_q & ~CASC_BIT) | ({W{casc_in}} & CASC_BIT);
        pend = eff & ~imr_q;
    end

    // fixed priority pick, lowest index wins
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_any = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    always_comb begin
        isr_any = 1'b0;
        isr_top = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (isr_q[i]) begin
                isr_any = 1'b1;
                isr_top = IW'(i);
            end
        end
    end

    assign int_out = win_any && (!isr_any || (win_idx < isr_top));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       imr_q <= '1;
        else if (mask_we) imr_q <= mask_din;
    end

    always_comb begin
        isr_d = isr_q;
        if (eoi && isr_any) isr_d[isr_top] = 1'b0;
        if (take)           isr_d[win_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !imr_q[win_idx]); // R2
    AST_TAKE_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> isr_q[$past(win_idx)]); // R6
    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !take && (isr_q != '0)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R7
    AST_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && isr_any) |-> (win_idx < isr_top)); // R6
endmodule

// File: rtl/intc_ack_fsm.sv
`timescale 1ns/1ps
module intc_ack_fsm
    import intc_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_int,
    input  logic          ack,
    input  logic [LW-1:0] line_in,
    output logic          cpu_irq,
    output logic          grant,
    output logic          vec_valid,
    output logic [LW-1:0] vec_line
);
    ack_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_int) state_d = ST_PEND;
            ST_PEND: begin
                if (!any_int)  state_d = ST_IDLE;
                else if (ack)  state_d = ST_VEC;
            end
            ST_VEC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_irq   = (state_q == ST_PEND);
        grant     = (state_q == ST_PEND) && ack && any_int;
        vec_valid = (state_q == ST_VEC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vec_line <= '0;
        else if (grant) vec_line <= line_in;
    end

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R5
    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> ($past(ack) && $past(cpu_irq))); // R10
    AST_DROP_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !any_int) |=> (!cpu_irq && !vec_valid)); // R8
endmodule

// File: rtl/cascade_intc.sv
`timescale 1ns/1ps
module cascade_intc
    import intc_pkg::*;
#(
    parameter int          UNIT_W   = 8,
    parameter int          CASC_POS = 2,
    parameter logic [7:0]  VEC_BASE = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*UNIT_W-1:0] req_in,
    input  logic                cmd_valid,
    input  logic                cmd_op,
    input  logic                cmd_sel,
    input  logic [UNIT_W-1:0]   cmd_data,
    input  logic                ack,
    output logic                cpu_irq,
    output logic                vec_valid,
    output logic [7:0]          vec_out
);
    localparam int IW = $clog2(UNIT_W);
    localparam int LW = IW + 1;

    logic          lo_int, hi_int;
    logic [IW-1:0] lo_win, hi_win;
    logic          grant;
    logic          lo_take, hi_take;
    logic          lo_mask_we, hi_mask_we, lo_eoi, hi_eoi;
    logic [LW-1:0] line_sel, vec_line;

    always_comb begin
        lo_mask_we = cmd_valid && (cmd_op == OP_MASK) && !cmd_sel;
        hi_mask_we = cmd_valid && (cmd_op == OP_MASK) &&  cmd_sel;
        lo_eoi     = cmd_valid && (cmd_op == OP_EOI)  && !cmd_sel;
        hi_eoi     = cmd_valid && (cmd_op == OP_EOI)  &&  cmd_sel;
    end

    intc_pri_unit #(.W(UNIT_W), .HAS_CASC(1'b0), .CASC_POS(CASC_POS)) u_hi (
        .clk(clk), .rst_n(rst_n),
        .req_lvl(req_in[2*UNIT_W-1:UNIT_W]), .casc_in(1'b0),
        .mask_we(hi_mask_we), .mask_din(cmd_data),
        .eoi(hi_eoi), .take(hi_take),
        .int_out(hi_int), .win_idx(hi_win)
    );

    intc_pri_unit #(.W(UNIT_W), .HAS_CASC(1'b1), .CASC_POS(CASC_POS)) u_lo (
        .clk(clk), .rst_n(rst_n),
        .req_lvl(req_in[UNIT_W-1:0]), .casc_in(hi_int),
        .mask_we(lo_mask_we), .mask_din(cmd_data),
        .eoi(lo_eoi), .take(lo_take),
        .int_out(lo_int), .win_idx(lo_win)
    );

    always_comb begin
        if (lo_win == IW'(CASC_POS)) line_sel = {1'b1, hi_win};
        else                         line_sel = {1'b0, lo_win};
        lo_take = grant;
        hi_take = grant && (lo_win == IW'(CASC_POS));
    end

    intc_ack_fsm #(.LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any_int(lo_int), .ack(ack), .line_in(line_sel),
        .cpu_irq(cpu_irq), .grant(grant),
        .vec_valid(vec_valid), .vec_line(vec_line)
    );

    assign vec_out = VEC_BASE + 8'(vec_line);

    AST_SLAVE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        hi_take |-> hi_int); // R4
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_out - VEC_BASE) < 8'(2*UNIT_W))); // R5
endmodule

// File: tb/sim_cascade_intc.sv
`timescale 1ns/1ps
module sim_cascade_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic        cmd_sel = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        ack = 1'b0;
    logic        cpu_irq, vec_valid;
    logic [7:0]  vec_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] BASE = 8'h20;

    always #5 clk = ~clk;

    cascade_intc u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .ack(ack),
        .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_in = '0; ack = 1'b0; cmd_valid = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic cmd(input logic op, input logic sel, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = d;
        wait_n(1);
        cmd_valid = 1'b0;
    endtask

    // acknowledge and return strobe and vector seen in the following cycle
    task automatic do_ack(output logic vv, output logic [7:0] v, output logic irq);
        ack = 1'b1;
        wait_n(1);
        vv = vec_valid; v = vec_out; irq = cpu_irq;
        ack = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        chk("R1 irq after reset", cpu_irq, 0);
        chk("R1 vec_valid after reset", vec_valid, 0);
        req_in[5] = 1'b1;
        wait_n(3);
        chk("R1 masked at reset", cpu_irq, 0);
        do_ack(vv, v, irq);
        chk("R10 ack idle ignored", vv, 0);
    endtask

    task automatic t_mask_and_level();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        cmd(1'b0, 1'b0, 8'h20);          // line 5 masked
        req_in[5] = 1'b1;
        wait_n(3);
        chk("R2 masked line", cpu_irq, 0);
        cmd(1'b0, 1'b0, 8'h00);
        wait_n(1);
        chk("R2 unmasked line raises irq", cpu_irq, 1);
        do_ack(vv, v, irq);
        chk("R5 vec strobe", vv, 1);
        chk("R5 vec value", v, BASE + 5);
        chk("R5 irq low in vector cycle", irq, 0);
        chk("R5 vec one cycle", vec_valid, 0);
        cmd(1'b1, 1'b0, 8'h00);
        wait_n(1);
        chk("R8 level still high re-raises", cpu_irq, 1);
        req_in[5] = 1'b0;
        wait_n(2);
        chk("R8 dropped line retires", cpu_irq, 0);
        do_ack(vv, v, irq);
        chk("R8 no vector for dropped line", vv, 0);
    endtask

    task automatic t_priority();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        req_in[6] = 1'b1; req_in[3] = 1'b1;
        wait_n(2);
        chk("R5 irq after two edges", cpu_irq, 1);
        do_ack(vv, v, irq);
        chk("R3 lower index wins", v, BASE + 3);
        req_in[3] = 1'b0;
        cmd(1'b1, 1'b0, 8'h00);
        wait_n(2);
        do_ack(vv, v, irq);
        chk("R3 next line served", v, BASE + 6);
    endtask

    task automatic t_cascade();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        cmd(1'b0, 1'b1, 8'h00);
        req_in[9] = 1'b1; req_in[3] = 1'b1;
        wait_n(2);
        do_ack(vv, v, irq);
        chk("R4 upper beats line 3", v, BASE + 9);
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        cmd(1'b0, 1'b1, 8'h00);
        req_in[9] = 1'b1; req_in[1] = 1'b1;
        wait_n(2);
        do_ack(vv, v, irq);
        chk("R4 line 1 beats upper", v, BASE + 1);
        do_reset();
        cmd(1'b0, 1'b0, 8'h04);
        cmd(1'b0, 1'b1, 8'h00);
        req_in[12] = 1'b1;
        wait_n(3);
        chk("R4 slot mask blocks upper", cpu_irq, 0);
    endtask

    task automatic t_nesting();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        req_in[5] = 1'b1;
        wait_n(2);
        do_ack(vv, v, irq);
        chk("R6 first vector", v, BASE + 5);
        req_in[6] = 1'b1;
        wait_n(3);
        chk("R6 lower blocked", cpu_irq, 0);
        req_in[3] = 1'b1;
        wait_n(2);
        chk("R6 higher nests", cpu_irq, 1);
        do_ack(vv, v, irq);
        chk("R6 nested vector", v, BASE + 3);
        req_in[3] = 1'b0; req_in[6] = 1'b0;
        cmd(1'b1, 1'b0, 8'h00);          // clears 3 only
        wait_n(3);
        chk("R7 eoi clears highest only", cpu_irq, 0);
        cmd(1'b1, 1'b0, 8'h00);          // clears 5
        wait_n(1);
        chk("R7 second eoi releases line", cpu_irq, 1);
    endtask

    task automatic t_eoi_cascade();
        logic vv; logic [7:0] v; logic irq;
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        cmd(1'b0, 1'b1, 8'h00);
        req_in[10] = 1'b1;
        wait_n(2);
        do_ack(vv, v, irq);
        chk("R4 upper vector", v, BASE + 10);
        req_in[10] = 1'b0; req_in[4] = 1'b1;
        cmd(1'b1, 1'b1, 8'h00);
        wait_n(3);
        chk("R7 upper eoi alone keeps slot", cpu_irq, 0);
        cmd(1'b1, 1'b0, 8'h00);
        wait_n(1);
        chk("R7 both eois release", cpu_irq, 1);
        do_ack(vv, v, irq);
        chk("R7 line 4 served", v, BASE + 4);
    endtask

    task automatic t_line2();
        do_reset();
        cmd(1'b0, 1'b0, 8'h00);
        req_in[2] = 1'b1;
        wait_n(4);
        chk("R9 req_in bit 2 ignored", cpu_irq, 0);
        chk("R9 no vector", vec_valid, 0);
    endtask

    initial begin
        t_reset();
        t_mask_and_level();
        t_priority();
        t_cascade();
        t_nesting();
        t_eoi_cascade();
        t_line2();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule